// File: doc/BRIEF.md
# Interleaved Multi-Bank Window Memory

This block stores a flat array of words across several single-port RAM banks. The number of banks is a power of two. Word `L` lives in bank `L mod LANES`, at row `L div LANES` of that bank. A single read request names any base location. The block then returns the `LANES` consecutive words that start at that base, all in one beat, whether or not the base is aligned to a bank boundary.

Each bank gets its own row address for the read. Banks below the base offset read the next row; the others read the base row. After the read, the bank outputs are rotated so the word at the base appears in lane 0. A window that runs past the top of the array continues at location 0, and a flag on the response marks that case.

Reads travel on a request channel and a response channel, both valid/ready. The response is registered and arrives one clock after the request is accepted. A new request is accepted only when the response register is empty or is being drained in the same cycle. If the consumer holds `rs_ready` low, the response stays frozen and requests are refused. Writes use a plain enable, one word per cycle, and never stall. Because the banks have a single port, a write cycle blocks the read channel for that cycle.

Top module: `iwm_window_mem`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at location `wr_addr`. Only the bank `wr_addr mod LANES`, row `wr_addr div LANES`, is enabled, and a later read covering that location returns the stored word.
- R2: When a request with base B is accepted on a rising edge, `rs_valid` is high after that edge. Lane k of `rs_data` (bits `k*WIDTH +: WIDTH`) then holds the word at location `(B + k) mod DEPTH`, for every k from 0 to LANES-1.
- R3: `rs_wrap` accompanies each response. It is 1 exactly when `B > DEPTH - LANES`, meaning the window crossed the last location.
- R4: While `rs_valid` is high and `rs_ready` is low, `rq_ready` is low. `rs_valid`, `rs_data` and `rs_wrap` hold unchanged, even if a write updates a location inside the held window.
- R5: While `wr_en` is high, `rq_ready` is low and no request is accepted. A write cycle therefore never produces a response.
- R6: After reset, `rs_valid` is 0 and `rq_ready` is 1.
- R7: A write changes only the addressed location. Neighbouring locations in the same row and in adjacent rows keep their values.
- R8: A response consumed with `rs_ready` high, with no new request accepted on that edge, leaves `rs_valid` low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | AW = log2(DEPTH) | Logical location to write |
| wr_data | input | WIDTH | Word to write |
| rq_valid | input | 1 | Read request present |
| rq_ready | output | 1 | Read request can be accepted this cycle |
| rq_base | input | AW | Base location of the requested window |
| rs_valid | output | 1 | Response window present |
| rs_ready | input | 1 | Consumer takes the response this cycle |
| rs_data | output | LANES*WIDTH | Window, lane k holds location base+k |
| rs_wrap | output | 1 | Window wrapped past the last location |

## Verification
A wrong per-bank row choice or rotation amount shows up in the very first response after the faulty request. The symptom is one or more lanes carrying a word from the wrong row or a shifted lane order, so every base offset from 0 to LANES-1 is read at least once. A corrupted hold path shows up as response data or the wrap flag changing on the cycle after a stall begins, including when a write lands inside the held window. A wrong bank enable on writes appears only when that location or a neighbour is read back, so writes are followed by reads that cover the adjacent words.

// File: rtl/iwm_pkg.sv
package iwm_pkg;
  // True when a window of `lanes` words from `base` runs past the array end.
  function automatic logic window_wraps(input int unsigned base,
                                        input int unsigned depth,
                                        input int unsigned lanes);
    return (base + lanes) > depth;
  endfunction
endpackage

// File: rtl/iwm_addr_gen.sv
module iwm_addr_gen #(
  parameter int LANES = 4,
  parameter int RW    = 4,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [RW-1:0]       row,
  input  logic [LW-1:0]       off,
  output logic [LANES*RW-1:0] bank_row
);
  // Banks below the offset hold the tail of the window, one row up.
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    assign bank_row[b*RW +: RW] = (LW'(b) < off) ? row + RW'(1) : row;
  end
endmodule

// File: rtl/iwm_bank.sv
module iwm_bank #(
  parameter int WIDTH = 8,
  parameter int ROWS  = 16,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [RW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [ROWS];

  // One port: a cycle either writes or reads; q holds when idle or writing.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end
endmodule

// File: rtl/iwm_rotate.sv
module iwm_rotate #(
  parameter int LANES = 4,
  parameter int WIDTH = 8,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES*WIDTH-1:0] bank_q,
  input  logic [LW-1:0]          off,
  output logic [LANES*WIDTH-1:0] lane_q
);
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [LW-1:0] src;
      src = off + LW'(k);
      lane_q[k*WIDTH +: WIDTH] = bank_q[src*WIDTH +: WIDTH];
    end
  end
endmodule

// File: rtl/iwm_window_mem.sv
module iwm_window_mem #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(LANES),
  localparam int RW   = AW - LW,
  localparam int ROWS = DEPTH / LANES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [WIDTH-1:0]       wr_data,
  input  logic                   rq_valid,
  output logic                   rq_ready,
  input  logic [AW-1:0]          rq_base,
  output logic                   rs_valid,
  input  logic                   rs_ready,
  output logic [LANES*WIDTH-1:0] rs_data,
  output logic                   rs_wrap
);
  import iwm_pkg::*;

  logic                   accept;
  logic [LANES*RW-1:0]    rd_row;
  logic [LANES*WIDTH-1:0] bank_q;
  logic [LW-1:0]          off_q;
  logic                   wrap_d;

  assign rq_ready = (!rs_valid || rs_ready) && !wr_en;
  assign accept   = rq_valid && rq_ready;
  assign wrap_d   = window_wraps({{(32-AW){1'b0}}, rq_base}, DEPTH, LANES);

  iwm_addr_gen #(.LANES(LANES), .RW(RW)) u_agen (
    .row      (rq_base[AW-1:LW]),
    .off      (rq_base[LW-1:0]),
    .bank_row (rd_row)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic          hit_wr;
    logic [RW-1:0] addr;
    assign hit_wr = wr_en && (wr_addr[LW-1:0] == LW'(b));
    assign addr   = wr_en ? wr_addr[AW-1:LW] : rd_row[b*RW +: RW];

    iwm_bank #(.WIDTH(WIDTH), .ROWS(ROWS)) u_bank (
      .clk   (clk),
      .en    (hit_wr || accept),
      .we    (wr_en),
      .addr  (addr),
      .wdata (wr_data),
      .q     (bank_q[b*WIDTH +: WIDTH])
    );
  end

  // Rotation amount and wrap flag travel with the bank read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      off_q    <= '0;
      rs_wrap  <= 1'b0;
    end else if (accept) begin
      rs_valid <= 1'b1;
      off_q    <= rq_base[LW-1:0];
      rs_wrap  <= wrap_d;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  iwm_rotate #(.LANES(LANES), .WIDTH(WIDTH)) u_rot (
    .bank_q (bank_q),
    .off    (off_q),
    .lane_q (rs_data)
  );
endmodule

// File: rtl/iwm_window_mem_chk.sv
module iwm_window_mem_chk #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   rq_valid,
  input logic                   rq_ready,
  input logic [AW-1:0]          rq_base,
  input logic                   rs_valid,
  input logic                   rs_ready,
  input logic [LANES*WIDTH-1:0] rs_data,
  input logic                   rs_wrap
);
  a_r2_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready) |=> rs_valid);

  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready) |=>
      (rs_wrap == (int'($past(rq_base)) > DEPTH - LANES)));

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data) && $stable(rs_wrap)));

  a_r4_refuse_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |-> !rq_ready);

  a_r5_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rq_ready);

  a_r8_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rs_valid) |-> $past(rs_ready));
endmodule

bind iwm_window_mem iwm_window_mem_chk #(.DEPTH(DEPTH), .LANES(LANES), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/iwm_window_mem_test.sv
`timescale 1ns/1ps
module iwm_window_mem_test;
  localparam int DEPTH = 64;
  localparam int LANES = 4;
  localparam int WIDTH = 8;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic rq_valid = 1'b0;
  logic rq_ready;
  logic [AW-1:0] rq_base = '0;
  logic rs_valid;
  logic rs_ready = 1'b1;
  logic [LANES*WIDTH-1:0] rs_data;
  logic rs_wrap;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [WIDTH-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  iwm_window_mem #(.DEPTH(DEPTH), .LANES(LANES), .WIDTH(WIDTH)) uut (.*);

  // {base[6:1], expected wrap[0]}
  localparam logic [6:0] VEC [0:11] = '{
    {6'd0, 1'b0}, {6'd1, 1'b0}, {6'd2, 1'b0}, {6'd3, 1'b0},
    {6'd5, 1'b0}, {6'd30, 1'b0}, {6'd59, 1'b0}, {6'd60, 1'b0},
    {6'd61, 1'b1}, {6'd62, 1'b1}, {6'd63, 1'b1}, {6'd17, 1'b0}};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_window(input string tag, input int base);
    for (int k = 0; k < LANES; k++)
      check(tag, 32'(rs_data[k*WIDTH +: WIDTH]), 32'(model[(base + k) % DEPTH]));
  endtask

  task automatic write_word(input int loc, input logic [WIDTH-1:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(loc); wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    model[loc] = val;
  endtask

  task automatic read_window(input int base, input logic exp_wrap);
    @(negedge clk);
    rq_valid = 1'b1; rq_base = AW'(base); rs_ready = 1'b1;
    @(negedge clk);
    rq_valid = 1'b0;
    check("R2 valid", 32'(rs_valid), 32'd1);
    check_window("R2 lanes", base);
    check("R3 wrap", 32'(rs_wrap), 32'(exp_wrap));
    @(negedge clk);
    check("R8 drop", 32'(rs_valid), 32'd0);
  endtask

  function automatic logic [WIDTH-1:0] fill(input int loc);
    return WIDTH'(loc * 3 + 5);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 rs_valid", 32'(rs_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 rq_ready", 32'(rq_ready), 32'd1);
    check("R6 rs_valid", 32'(rs_valid), 32'd0);

    for (int l = 0; l < DEPTH; l++) write_word(l, fill(l));   // R1 preload

    for (int i = 0; i < 12; i++) read_window(int'(VEC[i][6:1]), VEC[i][0]);

    // R4: stall holds response, even across a write into the window
    @(negedge clk);
    rs_ready = 1'b0; rq_valid = 1'b1; rq_base = 6'd10;
    @(negedge clk);
    rq_base = 6'd20;
    check("R4 valid", 32'(rs_valid), 32'd1);
    check("R4 refuse", 32'(rq_ready), 32'd0);
    repeat (2) begin
      @(negedge clk);
      check_window("R4 hold", 10);
    end
    wr_en = 1'b1; wr_addr = 6'd11; wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 1'b0;
    check_window("R4 hold after write", 10);
    check("R4 wrap held", 32'(rs_wrap), 32'd0);
    model[11] = 8'hA5;
    rs_ready = 1'b1;
    @(negedge clk);
    rq_valid = 1'b0;
    check("R4 next valid", 32'(rs_valid), 32'd1);
    check_window("R4 next window", 20);
    @(negedge clk);
    check("R8 drop", 32'(rs_valid), 32'd0);
    read_window(10, 1'b0);   // R1 written word visible

    // R5: write cycle blocks reads; R7: neighbours untouched
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd40; wr_data = 8'h3C;
    rq_valid = 1'b1; rq_base = 6'd38;
    #1;
    check("R5 refuse", 32'(rq_ready), 32'd0);
    @(negedge clk);
    wr_en = 1'b0;
    model[40] = 8'h3C;
    check("R5 no response", 32'(rs_valid), 32'd0);
    @(negedge clk);
    rq_valid = 1'b0;
    check("R7 valid", 32'(rs_valid), 32'd1);
    check_window("R7 neighbours", 38);
    @(negedge clk);
    read_window(41, 1'b0);   // R7 next row unchanged
    read_window(36, 1'b0);   // R7 previous row unchanged

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule